// File: doc/BRIEF.md
# Coherent Split-Resolution Reading Register Bank

This block holds the latest conversion results for a set of monitored channels. Software reads them through a simple address-and-strobe read port. Each reading is wider than a data byte. The upper byte of each channel has its own register. The leftover low-order bits of several channels are packed together into shared extended registers. Conversion results come in on a separate port that carries a channel index and the full-resolution value.

The two halves of a reading must come from the same conversion. To get that, the extended register is read first. That read locks the extended register and the upper-byte registers of every channel it covers. A channel's upper byte unlocks when software reads it. The shared extended register unlocks only after every channel it covers has had its upper byte read. A conversion that arrives while its channel is locked is kept, and only the newest one is kept. It shows up as soon as the lock releases. Reading an upper-byte register on its own, without the extended register first, locks nothing.

Every register is read-only and comes up as zero. With the default parameters there are five channels of 10 bits. The upper bytes sit at 0x20 to 0x24 and the two extended registers at 0x76 and 0x77.

Top module: `coherent_rdreg_bank`

## Requirements
- R1: After reset every mapped register (0x20..0x24, 0x76, 0x77) reads 0x00.
- R2: With no lock active, reading 0x20+c returns bits [9:2] of the latest conversion for channel c. The value appears on rd_data at the clock edge that samples the strobe.
- R3: Register 0x76 holds bits [1:0] of channels 0, 1, 2 and 3 in bit pairs [1:0], [3:2], [5:4] and [7:6]. Register 0x77 holds channel 4 bits [1:0] in [1:0], and its other bits read 0.
- R4: Reading an extended register locks the upper byte and low bits of every channel it covers. This includes a conversion that arrives in the same cycle as the read. Later conversions do not change what those registers read.
- R5: Reading a locked upper byte returns the locked value and releases that channel. From the next read on, it shows the newest conversion that arrived during the lock.
- R6: An extended register stays locked until every channel it covers has had its upper byte read. After that it shows the newest low bits.
- R7: Reading an upper byte that is not locked starts no lock. A later conversion is visible at once.
- R8: A conversion whose channel index is 5 or above changes no register.
- R9: A read of any address outside the map returns 0x00.
- R10: A lock taken through one extended register leaves channels covered by the other extended register free.
- R11: rd_data holds its value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 8 | Register address of the read |
| rd_data | output | 8 | Read data, registered on the strobe edge |
| cv_valid | input | 1 | Conversion result valid |
| cv_chan | input | 3 | Channel index of the conversion |
| cv_value | input | 10 | Full-resolution conversion value |

## Verification
The locking path is tried with several read orders: upper byte without the extended register first, extended register followed by upper bytes in shuffled order, and repeated extended reads while the lock is partly released. Each order separates a per-channel release from a group release. Conversions are injected while a channel is locked, while it is being released and after it is free. This shows whether the bank holds the old value, whether the newest pending value appears, and whether any stale data lingers. Values with distinct top and bottom bit patterns in every channel expose packing slips between bit pairs. Out-of-range channel indices, unmapped addresses and idle cycles confirm that nothing leaks through.

// File: rtl/crr_pkg.sv
package crr_pkg;

   // Integer ceiling division used for register counts.
   function automatic int ceil_div(input int num, input int den);
      return (num + den - 1) / den;
   endfunction

   // Bit mask of the channels that share one extended register.
   function automatic logic [31:0] group_mask(input int grp, input int per_grp, input int n_ch);
      logic [31:0] m;
      m = '0;
      for (int c = 0; c < n_ch; c++) begin
         if ((c / per_grp) == grp) m[c] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/crr_addr_dec.sv
module crr_addr_dec #(
   parameter int          ADDR_W   = 8,
   parameter int          NUM_CH   = 5,
   parameter int          NUM_EXT  = 2,
   parameter int unsigned MSB_BASE = 'h20,
   parameter int unsigned EXT_BASE = 'h76
) (
   input  logic                rd_en,
   input  logic [ADDR_W-1:0]   rd_addr,
   output logic [NUM_CH-1:0]   msb_hit,
   output logic [NUM_EXT-1:0]  ext_hit
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_msb
      assign msb_hit[c] = rd_en && (rd_addr == ADDR_W'(MSB_BASE + c));
   end

   for (genvar g = 0; g < NUM_EXT; g++) begin : g_ext
      assign ext_hit[g] = rd_en && (rd_addr == ADDR_W'(EXT_BASE + g));
   end

endmodule

// File: rtl/crr_chan_slot.sv
module crr_chan_slot #(
   parameter int RES_W  = 10,
   parameter int DATA_W = 8,
   localparam int LSB_W = RES_W - DATA_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cv_hit,
   input  logic [RES_W-1:0]  cv_value,
   input  logic              freeze_start,
   input  logic              msb_read,
   input  logic              grp_hold,
   output logic [DATA_W-1:0] msb_q,
   output logic [LSB_W-1:0]  lsb_q,
   output logic              owe
);

   // newest conversion, doubles as the pending store while locked
   logic [RES_W-1:0] latest;
   logic [RES_W-1:0] nxt;
   logic             msb_hold;

   assign nxt      = cv_hit ? cv_value : latest;
   assign msb_hold = (owe && !msb_read) || freeze_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         latest <= '0;
         msb_q  <= '0;
         lsb_q  <= '0;
         owe    <= 1'b0;
      end else begin
         latest <= nxt;
         if (!msb_hold) msb_q <= nxt[RES_W-1 -: DATA_W];
         if (!grp_hold) lsb_q <= nxt[LSB_W-1:0];
         if (freeze_start)  owe <= 1'b1;
         else if (msb_read) owe <= 1'b0;
      end
   end

endmodule

// File: rtl/crr_read_mux.sv
module crr_read_mux #(
   parameter int NUM_CH  = 5,
   parameter int NUM_EXT = 2,
   parameter int DATA_W  = 8,
   parameter int LSB_W   = 2
) (
   input  logic [NUM_CH*DATA_W-1:0] msb_flat,
   input  logic [NUM_CH*LSB_W-1:0]  lsb_flat,
   input  logic [NUM_CH-1:0]        msb_hit,
   input  logic [NUM_EXT-1:0]       ext_hit,
   output logic [DATA_W-1:0]        rd_next
);

   localparam int PAD_W = NUM_EXT*DATA_W - NUM_CH*LSB_W;

   logic [NUM_EXT*DATA_W-1:0] lsb_pad;

   if (PAD_W > 0) begin : g_pad
      assign lsb_pad = {{PAD_W{1'b0}}, lsb_flat};
   end else begin : g_nopad
      assign lsb_pad = lsb_flat;
   end

   always_comb begin
      rd_next = '0;
      for (int c = 0; c < NUM_CH; c++) begin
         if (msb_hit[c]) rd_next = rd_next | msb_flat[c*DATA_W +: DATA_W];
      end
      for (int g = 0; g < NUM_EXT; g++) begin
         if (ext_hit[g]) rd_next = rd_next | lsb_pad[g*DATA_W +: DATA_W];
      end
   end

endmodule

// File: rtl/coherent_rdreg_bank.sv
module coherent_rdreg_bank #(
   parameter int          ADDR_W   = 8,
   parameter int          DATA_W   = 8,
   parameter int          RES_W    = 10,
   parameter int          NUM_CH   = 5,
   parameter int          CHAN_W   = 3,
   parameter int unsigned MSB_BASE = 'h20,
   parameter int unsigned EXT_BASE = 'h76
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_en,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data,
   input  logic              cv_valid,
   input  logic [CHAN_W-1:0] cv_chan,
   input  logic [RES_W-1:0]  cv_value
);

   localparam int LSB_W   = RES_W - DATA_W;
   localparam int PER_EXT = (LSB_W > 0) ? DATA_W / LSB_W : 1;
   localparam int NUM_EXT = crr_pkg::ceil_div(NUM_CH, PER_EXT);

   // elaboration-time parameter checks
   if (RES_W <= DATA_W) begin : g_bad_res
      $error("RES_W must exceed DATA_W");
   end
   if ((LSB_W > 0) && (DATA_W % LSB_W != 0)) begin : g_bad_pack
      $error("DATA_W must be a multiple of RES_W - DATA_W");
   end
   if ((1 << CHAN_W) < NUM_CH) begin : g_bad_chan
      $error("CHAN_W too narrow for NUM_CH");
   end
   if (NUM_CH > 32) begin : g_bad_nch
      $error("NUM_CH limited to 32");
   end
   if ((MSB_BASE + NUM_CH > EXT_BASE) && (EXT_BASE + NUM_EXT > MSB_BASE)) begin : g_bad_map
      $error("address windows overlap");
   end
   if ((MSB_BASE + NUM_CH > (1 << ADDR_W)) || (EXT_BASE + NUM_EXT > (1 << ADDR_W))) begin : g_bad_addr
      $error("address window exceeds ADDR_W");
   end

   logic [NUM_CH-1:0]        msb_hit;
   logic [NUM_EXT-1:0]       ext_hit;
   logic [NUM_CH-1:0]        owe;
   logic [NUM_EXT-1:0]       grp_hold;
   logic [NUM_CH*DATA_W-1:0] msb_flat;
   logic [NUM_CH*LSB_W-1:0]  lsb_flat;
   logic [DATA_W-1:0]        rd_next;

   crr_addr_dec #(
      .ADDR_W   (ADDR_W),
      .NUM_CH   (NUM_CH),
      .NUM_EXT  (NUM_EXT),
      .MSB_BASE (MSB_BASE),
      .EXT_BASE (EXT_BASE)
   ) u_dec (
      .rd_en   (rd_en),
      .rd_addr (rd_addr),
      .msb_hit (msb_hit),
      .ext_hit (ext_hit)
   );

   // a group stays held while any member is locked and not being released
   for (genvar g = 0; g < NUM_EXT; g++) begin : g_grp
      localparam logic [31:0] MASK = crr_pkg::group_mask(g, PER_EXT, NUM_CH);
      assign grp_hold[g] = ext_hit[g] || (|(owe & ~msb_hit & MASK[NUM_CH-1:0]));
   end

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      crr_chan_slot #(
         .RES_W  (RES_W),
         .DATA_W (DATA_W)
      ) u_slot (
         .clk          (clk),
         .rst_n        (rst_n),
         .cv_hit       (cv_valid && (cv_chan == CHAN_W'(c))),
         .cv_value     (cv_value),
         .freeze_start (ext_hit[c / PER_EXT]),
         .msb_read     (msb_hit[c]),
         .grp_hold     (grp_hold[c / PER_EXT]),
         .msb_q        (msb_flat[c*DATA_W +: DATA_W]),
         .lsb_q        (lsb_flat[c*LSB_W +: LSB_W]),
         .owe          (owe[c])
      );
   end

   crr_read_mux #(
      .NUM_CH  (NUM_CH),
      .NUM_EXT (NUM_EXT),
      .DATA_W  (DATA_W),
      .LSB_W   (LSB_W)
   ) u_mux (
      .msb_flat (msb_flat),
      .lsb_flat (lsb_flat),
      .msb_hit  (msb_hit),
      .ext_hit  (ext_hit),
      .rd_next  (rd_next)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     rd_data <= '0;
      else if (rd_en) rd_data <= rd_next;
   end

endmodule

// File: rtl/coherent_rdreg_bank_chk.sv
module coherent_rdreg_bank_chk #(
   parameter int DATA_W  = 8,
   parameter int LSB_W   = 2,
   parameter int NUM_CH  = 5,
   parameter int NUM_EXT = 2,
   parameter int PER_EXT = 4
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     rd_en,
   input logic [DATA_W-1:0]        rd_data,
   input logic [NUM_CH-1:0]        owe,
   input logic [NUM_CH-1:0]        msb_hit,
   input logic [NUM_EXT-1:0]       ext_hit,
   input logic [NUM_CH*DATA_W-1:0] msb_flat,
   input logic [NUM_CH*LSB_W-1:0]  lsb_flat
);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_c
      localparam int G = c / PER_EXT;
      localparam logic [31:0] MASK = crr_pkg::group_mask(G, PER_EXT, NUM_CH);

      // R4
      msb_locked_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (owe[c] && !msb_hit[c]) |=> $stable(msb_flat[c*DATA_W +: DATA_W]));

      // R4
      ext_read_locks_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ext_hit[G] |=> owe[c]);

      // R5
      msb_read_releases_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (msb_hit[c] && !ext_hit[G]) |=> !owe[c]);

      // R7
      no_spurious_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
         (!owe[c] && !ext_hit[G]) |=> !owe[c]);

      // R6
      lsb_group_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
         ($countones(owe & ~msb_hit & MASK[NUM_CH-1:0]) != 0) |=> $stable(lsb_flat[c*LSB_W +: LSB_W]));
   end

   // R9
   unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_en && (msb_hit == '0) && (ext_hit == '0)) |=> (rd_data == '0));

   // R11
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rd_data));

endmodule

bind coherent_rdreg_bank coherent_rdreg_bank_chk #(
   .DATA_W  (DATA_W),
   .LSB_W   (LSB_W),
   .NUM_CH  (NUM_CH),
   .NUM_EXT (NUM_EXT),
   .PER_EXT (PER_EXT)
) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .rd_en    (rd_en),
   .rd_data  (rd_data),
   .owe      (owe),
   .msb_hit  (msb_hit),
   .ext_hit  (ext_hit),
   .msb_flat (msb_flat),
   .lsb_flat (lsb_flat)
);

// File: tb/coherent_rdreg_bank_bench.sv
module coherent_rdreg_bank_bench;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rd_en = 1'b0;
   logic [7:0] rd_addr = '0;
   logic [7:0] rd_data;
   logic       cv_valid = 1'b0;
   logic [2:0] cv_chan = '0;
   logic [9:0] cv_value = '0;

   int checks = 0;
   int errors = 0;
   logic       rd_seen = 1'b0;
   logic [7:0] exp_q[$];
   string      tag_q[$];

   coherent_rdreg_bank u_coherent_rdreg_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_en    (rd_en),
      .rd_addr  (rd_addr),
      .rd_data  (rd_data),
      .cv_valid (cv_valid),
      .cv_chan  (cv_chan),
      .cv_value (cv_value)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // monitor: a strobe seen at an edge means rd_data is due by the next falling edge
   always @(posedge clk) rd_seen <= rd_en;

   always @(negedge clk) begin
      if (rd_seen) begin
         checks++;
         if (exp_q.size() == 0) begin
            errors++;
            $display("FAIL scoreboard: read result with no expectation, got %02h", rd_data);
         end else begin
            logic [7:0] e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (rd_data !== e) begin
               errors++;
               $display("FAIL %s: actual %02h expected %02h", t, rd_data, e);
            end
         end
      end
   end

   // driver tasks are entered on a falling edge and leave on one
   task automatic rd(input logic [7:0] addr, input logic [7:0] exp, input string tag);
      rd_en   = 1'b1;
      rd_addr = addr;
      exp_q.push_back(exp);
      tag_q.push_back(tag);
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic conv(input logic [2:0] ch, input logic [9:0] val);
      cv_valid = 1'b1;
      cv_chan  = ch;
      cv_value = val;
      @(negedge clk);
      cv_valid = 1'b0;
   endtask

   // ext read and conversion in the same cycle
   task automatic rd_conv(input logic [7:0] addr, input logic [7:0] exp, input string tag,
                          input logic [2:0] ch, input logic [9:0] val);
      cv_valid = 1'b1;
      cv_chan  = ch;
      cv_value = val;
      rd(addr, exp, tag);
      cv_valid = 1'b0;
   endtask

   task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string tag);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      for (int a = 'h20; a <= 'h24; a++) rd(8'(a), 8'h00, "R1 msb reset");
      rd(8'h76, 8'h00, "R1 ext0 reset");
      rd(8'h77, 8'h00, "R1 ext1 reset");
      // release the locks taken by the ext reads
      for (int a = 'h20; a <= 'h24; a++) rd(8'(a), 8'h00, "R1 msb reset");

      // R2 upper bytes with no lock
      conv(3'd0, 10'h2A7);
      conv(3'd1, 10'h001);
      conv(3'd2, 10'h3FE);
      conv(3'd3, 10'h155);
      conv(3'd4, 10'h2C2);
      rd(8'h20, 8'hA9, "R2 ch0 msb");
      rd(8'h22, 8'hFF, "R2 ch2 msb");
      rd(8'h24, 8'hB0, "R2 ch4 msb");

      // R7 msb read alone does not lock
      conv(3'd0, 10'h100);
      rd(8'h20, 8'h40, "R7 ch0 follows new conversion");

      // R3 packing of the first ext register: ch3=01 ch2=10 ch1=01 ch0=00
      rd(8'h76, 8'h64, "R3 ext0 packing");

      // R4 locked values survive new conversions
      conv(3'd0, 10'h3FF);
      conv(3'd2, 10'h000);
      rd(8'h76, 8'h64, "R4 ext0 held");
      rd(8'h21, 8'h00, "R4 ch1 locked msb");
      rd(8'h20, 8'h40, "R4 ch0 locked msb");
      rd(8'h20, 8'hFF, "R5 ch0 pending applied");

      // R10 other group is free; R3 packing of the second ext register
      conv(3'd4, 10'h2C1);
      rd(8'h24, 8'hB0, "R10 ch4 unaffected by group 0 lock");
      rd(8'h77, 8'h01, "R3 ext1 packing");
      conv(3'd4, 10'h002);
      rd(8'h24, 8'hB0, "R4 ch4 locked msb");
      rd(8'h24, 8'h00, "R5 ch4 pending applied");
      rd(8'h77, 8'h02, "R6 ext1 refreshed after release");
      rd(8'h24, 8'h00, "R5 ch4 release");

      // R6 group 0 finishes releasing
      rd(8'h22, 8'hFF, "R4 ch2 locked msb");
      rd(8'h23, 8'h55, "R4 ch3 locked msb");
      // ch3=01 ch2=00 ch1=01 ch0=11
      rd(8'h76, 8'h47, "R6 ext0 refreshed after release");
      rd(8'h22, 8'h00, "R5 ch2 pending applied");
      rd(8'h20, 8'hFF, "R5 ch0 release");
      rd(8'h21, 8'h00, "R5 ch1 release");
      rd(8'h23, 8'h55, "R5 ch3 release");

      // R4 conversion in the same cycle as the ext read is held back
      rd_conv(8'h76, 8'h47, "R4 ext0 same-cycle conversion", 3'd1, 10'h3C2);
      rd(8'h21, 8'h00, "R4 ch1 msb held on same-cycle conversion");
      rd(8'h21, 8'hF0, "R5 ch1 same-cycle value applied");
      rd(8'h20, 8'hFF, "R5 ch0 release");
      rd(8'h22, 8'h00, "R5 ch2 release");
      rd(8'h23, 8'h55, "R5 ch3 release");
      // ch3=01 ch2=00 ch1=10 ch0=11
      rd(8'h76, 8'h4B, "R6 ext0 shows same-cycle low bits");
      for (int a = 'h20; a <= 'h23; a++) rd(8'(a), (a == 'h20) ? 8'hFF : (a == 'h21) ? 8'hF0 : (a == 'h22) ? 8'h00 : 8'h55, "R5 final release");

      // R8 out-of-range channel indices
      conv(3'd5, 10'h3FF);
      conv(3'd7, 10'h2AA);
      rd(8'h20, 8'hFF, "R8 ch0 untouched");
      rd(8'h21, 8'hF0, "R8 ch1 untouched");
      rd(8'h22, 8'h00, "R8 ch2 untouched");
      rd(8'h23, 8'h55, "R8 ch3 untouched");
      rd(8'h24, 8'h00, "R8 ch4 untouched");
      rd(8'h77, 8'h02, "R8 ext1 untouched");
      rd(8'h24, 8'h00, "R8 ch4 release");

      // R9 unmapped addresses
      rd(8'h25, 8'h00, "R9 gap above msb window");
      rd(8'h1F, 8'h00, "R9 gap below msb window");
      rd(8'h78, 8'h00, "R9 gap above ext window");

      // R11 rd_data holds with no strobe
      rd(8'h23, 8'h55, "R11 setup");
      conv(3'd3, 10'h000);
      repeat (3) @(negedge clk);
      chk(rd_data, 8'h55, "R11 idle hold");

      repeat (2) @(negedge clk);
      checks++;
      if (exp_q.size() != 0) begin
         errors++;
         $display("FAIL scoreboard: actual %0d leftover expected 0", exp_q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule